// File: doc/BRIEF.md
# Framebuffer Write Scheduler

This block accepts pixel writes from a host and moves them into a single-port video RAM that a raster display engine also reads. Each host request carries a 16-bit pixel address (enough to reach every byte of a 64 KiB, 256 x 256 buffer) and an 8-bit intensity value. Requests wait in a queue built from two parallel stores, one for addresses and one for intensities. Both stores always push and pop together, so the head of the queue is always a matching pair.

The scheduler has two ways of sharing the RAM with the display.
- **Blanking-window mode** (`mode_il` = 0). Writes happen only while the timing generator reports non-visible time: porches, sync pulses and vertical blanking.
- **Interleaved mode** (`mode_il` = 1). The RAM clock runs at twice the pixel rate. Read slots and write slots alternate, so display fetches are never delayed.

Whenever the RAM port is not writing, it carries the display read address.

The controller has four named states:
- `ST_HOLD`: visible scan in blanking-window mode. The RAM port follows the display.
- `ST_WIN`: blanking window. Writes are allowed.
- `ST_IL_RD`: interleaved read slot.
- `ST_IL_WR`: interleaved write slot.

The transitions are:
- `ST_HOLD` goes to `ST_WIN` when `disp_active` is low. It goes to `ST_IL_RD` when `mode_il` is high.
- `ST_WIN` goes to `ST_HOLD` when `disp_active` is high. It goes to `ST_IL_RD` when `mode_il` is high.
- `ST_IL_RD` goes to `ST_IL_WR`.
- `ST_IL_WR` goes to `ST_IL_RD`.
- Either interleaved state goes to `ST_HOLD` when `mode_il` falls.

Top module: `fbw_sched`

## Requirements
- R1: After reset, `q_empty`=1, `q_full`=0, `ovf_flag`=0, `ram_we`=0, and the controller is in `ST_HOLD`.
- R2: Queued entries reach the RAM strictly in the order they were accepted. Each write presents the address and the intensity that were pushed together.
- R3: A push made while `q_full` is 1 is discarded and is never written. It sets `ovf_flag`, which stays 1 until reset.
- R4: `q_full` and `q_empty` are registered. After every clock edge, `q_full` is 1 exactly when DEPTH entries are held and `q_empty` is 1 exactly when none are held.
- R5: In blanking-window mode (`mode_il`=0), `ram_we` is never 1 in a cycle where `disp_active`=1.
- R6: In blanking-window mode, the first cycle in which `disp_active` is seen low at a clock edge is a state change only, with no write. From the next cycle on, one entry is written per cycle while `disp_active`=0 and the queue is not empty.
- R7: When `ram_we`=0, `ram_addr` equals `disp_raddr`. When `ram_we`=1, `ram_addr` and `ram_wdata` carry the head entry, which is popped at that clock edge.
- R8: In interleaved mode (`mode_il`=1), the first slot after entering the mode is a read slot. Slots then alternate read/write every clock. `ram_we` can be 1 only in a write slot, and it is 1 whenever the queue is not empty, whatever the value of `disp_active`.
- R9: `fetch_slot` is 1 in every interleaved read slot and 0 in every interleaved write slot. In blanking-window mode it is the inverse of `ram_we`.
- R10: When `mode_il` falls, the controller goes to `ST_HOLD`, so the following cycle carries no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM clock (twice the pixel rate in interleaved use) |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_il | input | 1 | 0 = blanking-window mode, 1 = interleaved mode |
| disp_active | input | 1 | 1 during visible scan, 0 in porches, sync and vertical blanking |
| disp_raddr | input | AW | Display fetch address from the raster engine |
| push_valid | input | 1 | Host write request |
| push_addr | input | AW | Framebuffer address of the request |
| push_data | input | DW | Intensity value of the request |
| q_full | output | 1 | Queue full (registered) |
| q_empty | output | 1 | Queue empty (registered) |
| ovf_flag | output | 1 | Sticky flag: a push was discarded |
| ram_addr | output | AW | RAM address (display or queue head) |
| ram_wdata | output | DW | RAM write data (queue head intensity) |
| ram_we | output | 1 | RAM write enable; pops the queue head |
| fetch_slot | output | 1 | RAM address this cycle is a display fetch |

## Verification
The hardest situation to reach from the ports is a write decision that coincides with an edge of `disp_active` or a change of `mode_il`, while the queue holds a mix of entries that were accepted and entries that were discarded. The bench sweeps the period and duty of `disp_active` over many combinations, with push attempts on an irregular cadence. It uses a shallow queue so that it fills and overflows often. It toggles `mode_il` while entries are still pending.

A reference model in the bench tracks slot state and occupancy cycle by cycle, taken from the requirements. It compares every cycle's `ram_we`, address, data, flags and `fetch_slot` against that model.

// File: rtl/fbws_pkg.sv
package fbws_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_WIN   = 2'd1,
        ST_IL_RD = 2'd2,
        ST_IL_WR = 2'd3
    } fbws_state_e;

endpackage

// File: rtl/fbws_fifo.sv
module fbws_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          do_push;
    logic          do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cnt_nxt = cnt;
        if (do_push && !do_pop) begin
            cnt_nxt = cnt + 1'b1;
        end else if (!do_push && do_pop) begin
            cnt_nxt = cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            empty  <= 1'b1;
            full   <= 1'b0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            cnt   <= cnt_nxt;
            empty <= (cnt_nxt == '0);
            full  <= (cnt_nxt == CW'(DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= din;
        end
    end

    assign dout = store[rd_ptr];

endmodule

// File: rtl/fbws_ctrl.sv
module fbws_ctrl
    import fbws_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_il,
    input  logic        disp_active,
    input  logic        q_empty,
    output logic        wr_en,
    output logic        fetch_slot,
    output fbws_state_e state
);
    fbws_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (mode_il) begin
                    state_nxt = ST_IL_RD;
                end else if (!disp_active) begin
                    state_nxt = ST_WIN;
                end
            end
            ST_WIN: begin
                if (mode_il) begin
                    state_nxt = ST_IL_RD;
                end else if (disp_active) begin
                    state_nxt = ST_HOLD;
                end
            end
            ST_IL_RD: state_nxt = mode_il ? ST_IL_WR : ST_HOLD;
            ST_IL_WR: state_nxt = mode_il ? ST_IL_RD : ST_HOLD;
            default:  state_nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        wr_en      = 1'b0;
        fetch_slot = 1'b1;
        unique case (state)
            ST_HOLD: begin
                wr_en      = 1'b0;
                fetch_slot = 1'b1;
            end
            ST_WIN: begin
                wr_en      = !q_empty && !disp_active && !mode_il;
                fetch_slot = !wr_en;
            end
            ST_IL_RD: begin
                wr_en      = 1'b0;
                fetch_slot = 1'b1;
            end
            ST_IL_WR: begin
                wr_en      = !q_empty && mode_il;
                fetch_slot = 1'b0;
            end
            default: begin
                wr_en      = 1'b0;
                fetch_slot = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fbws_port_mux.sv
module fbws_port_mux #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          sel_wr,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic [AW-1:0] disp_addr,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);
    assign ram_addr  = sel_wr ? head_addr : disp_addr;
    assign ram_wdata = head_data;
endmodule

// File: rtl/fbw_sched.sv
module fbw_sched
    import fbws_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_il,
    input  logic          disp_active,
    input  logic [AW-1:0] disp_raddr,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          q_full,
    output logic          q_empty,
    output logic          ovf_flag,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic          fetch_slot
);
    logic          push_ok;
    logic          a_empty;
    logic          a_full;
    logic          d_empty;
    logic          d_full;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    fbws_state_e   state;

    assign push_ok = push_valid && !q_full;
    assign q_full  = a_full;
    assign q_empty = a_empty;

    fbws_fifo #(.W(AW), .DEPTH(DEPTH)) u_afifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .pop   (ram_we),
        .din   (push_addr),
        .dout  (head_addr),
        .empty (a_empty),
        .full  (a_full)
    );

    fbws_fifo #(.W(DW), .DEPTH(DEPTH)) u_dfifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .pop   (ram_we),
        .din   (push_data),
        .dout  (head_data),
        .empty (d_empty),
        .full  (d_full)
    );

    fbws_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_il     (mode_il),
        .disp_active (disp_active),
        .q_empty     (q_empty),
        .wr_en       (ram_we),
        .fetch_slot  (fetch_slot),
        .state       (state)
    );

    fbws_port_mux #(.AW(AW), .DW(DW)) u_mux (
        .sel_wr    (ram_we),
        .head_addr (head_addr),
        .head_data (head_data),
        .disp_addr (disp_raddr),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (push_valid && q_full) begin
            ovf_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/fbw_sched_chk.sv
module fbw_sched_chk
    import fbws_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mode_il,
    input logic        disp_active,
    input logic        push_valid,
    input logic        q_full,
    input logic        q_empty,
    input logic        ovf_flag,
    input logic        ram_we,
    input logic        fetch_slot,
    input logic        a_empty,
    input logic        d_empty,
    input logic        a_full,
    input logic        d_full,
    input fbws_state_e state
);
    AST_LOCKSTEP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) a_empty == d_empty); // R2
    AST_LOCKSTEP_FULL: assert property (@(posedge clk) disable iff (!rst_n) a_full == d_full); // R2
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> !q_empty); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |=> ovf_flag); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (push_valid && q_full) |=> ovf_flag); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(q_full && q_empty)); // R4
    AST_NO_WE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n) (!mode_il && disp_active) |-> !ram_we); // R5
    AST_WINDOW_LEAD: assert property (@(posedge clk) disable iff (!rst_n) (!mode_il && $past(!mode_il) && $past(disp_active)) |-> !ram_we); // R6
    AST_IL_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n) (mode_il && ram_we) |=> !ram_we); // R8
    AST_IL_WR_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IL_WR) |-> !fetch_slot); // R9
    AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n) $fell(mode_il) |=> (state == ST_HOLD && !ram_we)); // R10
endmodule

bind fbw_sched fbw_sched_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_il     (mode_il),
    .disp_active (disp_active),
    .push_valid  (push_valid),
    .q_full      (q_full),
    .q_empty     (q_empty),
    .ovf_flag    (ovf_flag),
    .ram_we      (ram_we),
    .fetch_slot  (fetch_slot),
    .a_empty     (a_empty),
    .d_empty     (d_empty),
    .a_full      (a_full),
    .d_full      (d_full),
    .state       (state)
);

// File: tb/tb_fbw_sched.sv
module tb_fbw_sched;
    localparam int AW    = 16;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int LOGN  = 2048;

    localparam int M_HOLD = 0;
    localparam int M_WIN  = 1;
    localparam int M_ILR  = 2;
    localparam int M_ILW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_il = 1'b0;
    logic          disp_active = 1'b1;
    logic [AW-1:0] disp_raddr = '0;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic [DW-1:0] push_data = '0;
    logic          q_full;
    logic          q_empty;
    logic          ovf_flag;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we;
    logic          fetch_slot;

    fbw_sched #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_il     (mode_il),
        .disp_active (disp_active),
        .disp_raddr  (disp_raddr),
        .push_valid  (push_valid),
        .push_addr   (push_addr),
        .push_data   (push_data),
        .q_full      (q_full),
        .q_empty     (q_empty),
        .ovf_flag    (ovf_flag),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .ram_we      (ram_we),
        .fetch_slot  (fetch_slot)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;

    int m_state = M_HOLD;
    int m_cnt   = 0;
    bit m_ovf   = 1'b0;
    logic [AW-1:0] log_a [LOGN];
    logic [DW-1:0] log_d [LOGN];
    int wr_idx = 0;
    int rd_idx = 0;
    int n_writes = 0;
    int n_vis_writes = 0;
    int seq = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model evaluated mid-cycle, then advanced for the coming edge
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            bit exp_we;
            bit exp_fetch;
            bit accept;
            int nxt;
            exp_we = 1'b0;
            if (m_state == M_WIN) exp_we = (m_cnt > 0) && !disp_active && !mode_il;
            if (m_state == M_ILW) exp_we = (m_cnt > 0) && mode_il;
            if (m_state == M_ILR) exp_fetch = 1'b1;
            else if (m_state == M_ILW) exp_fetch = 1'b0;
            else exp_fetch = !exp_we;

            chk(ram_we == exp_we, (m_state >= M_ILR) ? "R8" : (disp_active ? "R5" : "R6"),
                "ram_we", ram_we, exp_we);
            chk(q_full == (m_cnt == DEPTH), "R4", "q_full", q_full, m_cnt == DEPTH);
            chk(q_empty == (m_cnt == 0), "R4", "q_empty", q_empty, m_cnt == 0);
            chk(ovf_flag == m_ovf, "R3", "ovf_flag", ovf_flag, m_ovf);
            chk(fetch_slot == exp_fetch, "R9", "fetch_slot", fetch_slot, exp_fetch);
            if (exp_we && ram_we) begin
                chk(ram_addr == log_a[rd_idx], "R2", "write address", ram_addr, log_a[rd_idx]);
                chk(ram_wdata == log_d[rd_idx], "R2", "write data", ram_wdata, log_d[rd_idx]);
            end else if (!ram_we) begin
                chk(ram_addr == disp_raddr, "R7", "display address", ram_addr, disp_raddr);
            end

            accept = push_valid && (m_cnt != DEPTH);
            if (push_valid && m_cnt == DEPTH) m_ovf = 1'b1;
            if (accept) begin
                log_a[wr_idx] = push_addr;
                log_d[wr_idx] = push_data;
                wr_idx++;
                m_cnt++;
            end
            if (exp_we) begin
                rd_idx++;
                m_cnt--;
                n_writes++;
                if (disp_active) n_vis_writes++;
            end
            nxt = m_state;
            case (m_state)
                M_HOLD: nxt = mode_il ? M_ILR : (!disp_active ? M_WIN : M_HOLD);
                M_WIN:  nxt = mode_il ? M_ILR : (disp_active ? M_HOLD : M_WIN);
                M_ILR:  nxt = mode_il ? M_ILW : M_HOLD;
                default: nxt = mode_il ? M_ILR : M_HOLD;
            endcase
            m_state = nxt;
        end
    end

    task automatic step(input bit pv, input bit da, input bit md);
        @(posedge clk);
        #1;
        mode_il     = md;
        disp_active = da;
        disp_raddr  = disp_raddr + 16'd3;
        push_valid  = pv;
        if (pv) begin
            push_addr = AW'(seq * 16'h0101 + 16'h0033);
            push_data = DW'(seq) ^ 8'h5A;
            seq++;
        end
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(q_empty == 1'b1, "R1", "q_empty in reset", q_empty, 1);
        chk(q_full == 1'b0, "R1", "q_full in reset", q_full, 0);
        chk(ovf_flag == 1'b0, "R1", "ovf_flag in reset", ovf_flag, 0);
        chk(ram_we == 1'b0, "R1", "ram_we in reset", ram_we, 0);
        @(posedge clk);
        #1;
        rst_n  = 1'b1;
        mon_on = 1'b1;

        // Fill during visible scan, one extra push is discarded (R3, R4, R5)
        for (int i = 0; i < DEPTH + 1; i++) step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(q_full == 1'b1, "R4", "full after DEPTH pushes", q_full, 1);
        chk(ovf_flag == 1'b1, "R3", "overflow after push on full", ovf_flag, 1);
        chk(n_writes == 0, "R5", "writes during visible scan", n_writes, 0);

        // Three blank cycles give exactly two writes (R6)
        w0 = n_writes;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(n_writes - w0 == 2, "R6", "writes in three-cycle window", n_writes - w0, 2);

        // Sweep display period and duty with irregular pushes
        for (int p = 2; p <= 7; p++) begin
            for (int k = 1; k < p; k++) begin
                for (int c = 0; c < 36; c++) begin
                    step(((c * 7 + p + k) % 3) != 0, (c % p) < k, 1'b0);
                end
            end
        end

        // Interleaved mode with display mostly visible (R8)
        w0 = n_vis_writes;
        for (int c = 0; c < 120; c++) step((c % 4) != 3, (c % 9) != 0, 1'b1);
        @(negedge clk);
        chk(n_vis_writes > w0, "R8", "writes while visible in interleaved mode",
            n_vis_writes - w0, 1);

        // Mode toggling with pending entries (R10)
        for (int r = 0; r < 12; r++) begin
            for (int c = 0; c < 5; c++) step(1'b1, 1'b0, 1'b1);
            for (int c = 0; c < 3 + (r % 4); c++) step(c == 0, 1'b0, 1'b0);
        end

        // Drain and final state (R2, R3)
        for (int c = 0; c < 20; c++) step(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk(rd_idx == wr_idx, "R2", "all accepted entries written", rd_idx, wr_idx);
        chk(q_empty == 1'b1, "R4", "empty after drain", q_empty, 1);
        chk(ovf_flag == 1'b1, "R3", "overflow still set", ovf_flag, 1);

        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule